// File: doc/BRIEF.md
# Quadrature Direct Digital Synthesizer

The block generates a sine and a cosine tone of software-selectable frequency for a three-channel video DAC that is used as a continuous audio converter. A 32-bit phase accumulator steps by a tuning word on every cycle of the 50 MHz clock, with no processor involvement. Software on a host loads the tuning word through a write strobe. The output frequency is `tuning_word * 50e6 / 2^32`, so a host that wants 1 Hz per unit of an 8-bit control value writes `round(n * 2^32 / 50e6)`. For n = 255 that is 21904.

The top eight accumulator bits appear directly on an 8-bit digital port as a sawtooth. The top port pin therefore toggles at the synthesized frequency. The same eight bits index a 256-entry sine table that is built at elaboration. A second read of that table at the index plus 64, a quarter turn, yields a cosine that stays exactly in quadrature with the sine. Both samples are registered and leave as 10-bit offset-binary codes: the sine on the red channel and the cosine on the blue channel. The DAC's active-low blank and sync controls are tied inactive, so the converter never pauses.

Top module: `quad_dds`

## Requirements
- R1: On every clock with `rst` low, the phase advances by the current tuning word modulo 2^32, and `saw_port` always equals phase bits [31:24].
- R2: A word presented with `tune_we` high at a clock edge is first added to the phase at the following edge. The phase is not cleared by the write.
- R3: With `tune_we` low, the tuning word keeps its value, so the phase keeps stepping by the same amount.
- R4: `dac_blue` is the table sample at phase index (idx + 64) mod 256, where idx is phase bits [31:24]. This puts the blue channel a quarter cycle ahead of red.
- R5: The table sample at index i is within 2 codes of 512 + 511*sin(2*pi*i/256). Samples lie in 1..1023, with 512 at indexes 0 and 128, 1023 at index 64 and 1 at index 192.
- R6: `dac_blank_n` and `dac_sync_n` are high in every cycle.
- R7: A clock edge with `rst` high clears the phase and the tuning word to 0, sets `dac_red` to 512 and sets `dac_blue` to 1023, which are the table values for phase 0.
- R8: `dac_red` and `dac_blue` are registered. After each edge they show the samples for the phase index held before that edge, so both channels have the same one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz sample clock |
| rst | input | 1 | synchronous reset, active high |
| tune_we | input | 1 | load strobe for the tuning word |
| tune_word | input | 32 | new phase increment |
| saw_port | output | 8 | top phase bits, sawtooth |
| dac_red | output | 10 | sine sample, offset binary |
| dac_blue | output | 10 | cosine sample, offset binary |
| dac_blank_n | output | 1 | DAC blank control, held high |
| dac_sync_n | output | 1 | DAC sync control, held high |

## Verification
The assertions take for granted that reset is held high for at least three clocks after start-up. This keeps the two-cycle look-back in the quadrature property inside the span since reset. The quadrature property only applies while the tuning word is exactly 2^30. In that case one step moves the index by 64, and red must repeat the previous blue sample. The stimulus holds reset for four cycles and then runs that quarter-turn word for a stretch without a reset. It also exercises a single-step sweep over every index, the 255 Hz word, a backward step through the wrap, back-to-back word writes, and a reset during a run.

// File: rtl/quad_dds.sv
module quad_dds #(
  parameter int PHASE_W  = 32,
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 10,
  parameter int PORT_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tune_we,
  input  logic [PHASE_W-1:0]  tune_word,
  output logic [PORT_W-1:0]   saw_port,
  output logic [SAMPLE_W-1:0] dac_red,
  output logic [SAMPLE_W-1:0] dac_blue,
  output logic                dac_blank_n,
  output logic                dac_sync_n
);
  localparam int DEPTH = 2 ** ADDR_W;
  localparam int HALF  = DEPTH / 2;
  localparam int QTR   = DEPTH / 4;
  localparam int MID   = 2 ** (SAMPLE_W - 1);
  localparam int AMP   = MID - 1;
  localparam logic [ADDR_W-1:0]   QTR_OFS  = ADDR_W'(QTR);
  localparam logic [SAMPLE_W-1:0] MID_CODE = SAMPLE_W'(MID);
  localparam logic [SAMPLE_W-1:0] TOP_CODE = SAMPLE_W'(MID + AMP);

  // integer half-wave approximation: 16p / (5h^2 - 4p), p = k(h-k)
  function automatic logic [DEPTH*SAMPLE_W-1:0] build_wave();
    logic [DEPTH*SAMPLE_W-1:0] t;
    longint h, a, m, k, p, den, s;
    t = '0;
    h = longint'(HALF);
    a = longint'(AMP);
    m = longint'(MID);
    for (int i = 0; i < DEPTH; i++) begin
      k   = longint'(i % HALF);
      p   = k * (h - k);
      den = 5 * h * h - 4 * p;
      s   = (16 * a * p + den / 2) / den;
      t[i*SAMPLE_W +: SAMPLE_W] = (i < HALF) ? SAMPLE_W'(m + s) : SAMPLE_W'(m - s);
    end
    return t;
  endfunction

  localparam logic [DEPTH*SAMPLE_W-1:0] WAVE = build_wave();

  logic [PHASE_W-1:0]  acc;
  logic [PHASE_W-1:0]  ftw;
  logic [SAMPLE_W-1:0] red_q, blue_q;
  logic [ADDR_W-1:0]   sin_idx, cos_idx;

  assign sin_idx = acc[PHASE_W-1 -: ADDR_W];
  assign cos_idx = sin_idx + QTR_OFS;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      ftw    <= '0;
      red_q  <= MID_CODE;
      blue_q <= TOP_CODE;
    end else begin
      acc    <= acc + ftw;
      red_q  <= WAVE[sin_idx*SAMPLE_W +: SAMPLE_W];
      blue_q <= WAVE[cos_idx*SAMPLE_W +: SAMPLE_W];
      if (tune_we) ftw <= tune_word;
    end
  end

  assign saw_port    = acc[PHASE_W-1 -: PORT_W];
  assign dac_red     = red_q;
  assign dac_blue    = blue_q;
  assign dac_blank_n = 1'b1;
  assign dac_sync_n  = 1'b1;
endmodule

// File: rtl/quad_dds_chk.sv
module quad_dds_chk #(
  parameter int PHASE_W  = 32,
  parameter int SAMPLE_W = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                tune_we,
  input logic [PHASE_W-1:0]  acc,
  input logic [PHASE_W-1:0]  ftw,
  input logic [SAMPLE_W-1:0] dac_red,
  input logic [SAMPLE_W-1:0] dac_blue,
  input logic                dac_blank_n,
  input logic                dac_sync_n
);
  localparam logic [PHASE_W-1:0]  QUARTER = PHASE_W'(1) << (PHASE_W - 2);
  localparam logic [SAMPLE_W-1:0] LOW     = SAMPLE_W'(1);
  localparam logic [SAMPLE_W-1:0] MID     = SAMPLE_W'(2 ** (SAMPLE_W - 1));
  localparam logic [SAMPLE_W-1:0] TOP     = SAMPLE_W'(2 ** SAMPLE_W - 1);

  assert_ctrl_high_R6: assert property (@(posedge clk) disable iff (rst)
    dac_blank_n && dac_sync_n);

  assert_reset_state_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc == '0 && ftw == '0 && dac_red == MID && dac_blue == TOP));

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !tune_we |=> $stable(ftw));

  assert_sample_range_R5: assert property (@(posedge clk) disable iff (rst)
    dac_red >= LOW && dac_blue >= LOW);

  // R4 with R8: a quarter-turn step makes red repeat the previous blue sample
  assert_quadrature_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(ftw, 2) == QUARTER) |-> dac_red == $past(dac_blue));
endmodule

bind quad_dds quad_dds_chk #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .tune_we(tune_we), .acc(acc), .ftw(ftw),
  .dac_red(dac_red), .dac_blue(dac_blue),
  .dac_blank_n(dac_blank_n), .dac_sync_n(dac_sync_n)
);

// File: tb/test_quad_dds.sv
module test_quad_dds;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tune_we = 1'b0;
  logic [31:0] tune_word = '0;
  logic [7:0]  saw_port;
  logic [9:0]  dac_red, dac_blue;
  logic        dac_blank_n, dac_sync_n;

  always #10 clk = ~clk;

  quad_dds i_quad_dds (
    .clk(clk), .rst(rst), .tune_we(tune_we), .tune_word(tune_word),
    .saw_port(saw_port), .dac_red(dac_red), .dac_blue(dac_blue),
    .dac_blank_n(dac_blank_n), .dac_sync_n(dac_sync_n)
  );

  typedef struct {
    logic [7:0] saw;
    int         red;
    int         blue;
    int         tol;
    string      tag;
  } exp_t;

  exp_t        sb[$];
  int          total = 0;
  int          bad = 0;
  logic [31:0] acc_m = '0;
  logic [31:0] ftw_m = '0;

  function automatic int ref_wave(int idx);
    real v;
    v = 511.0 * $sin(2.0 * 3.14159265358979 * real'(idx) / 256.0);
    return 512 + $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
  endfunction

  function automatic int absdiff(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes what the next edge must show
  task automatic step(bit r, bit we, logic [31:0] d, string tag);
    exp_t e;
    int idx;
    @(negedge clk);
    rst = r; tune_we = we; tune_word = d;
    idx = int'(acc_m[31:24]);
    if (r) begin
      acc_m = '0; ftw_m = '0;
      e.red = 512; e.blue = 1023; e.tol = 0; e.tag = "R7";
    end else begin
      e.red  = ref_wave(idx);
      e.blue = ref_wave((idx + 64) % 256);
      e.tol  = 2;
      e.tag  = tag;
      acc_m  = acc_m + ftw_m;
      if (we) ftw_m = d;
    end
    e.saw = acc_m[31:24];
    sb.push_back(e);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 32'h0, tag);
  endtask

  // monitor: samples a quarter period after each rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check(saw_port == e.saw, e.tag, "saw_port (R1)", int'(saw_port), int'(e.saw));
        check(absdiff(int'(dac_red), e.red) <= e.tol, e.tag, "dac_red (R5,R8)", int'(dac_red), e.red);
        check(absdiff(int'(dac_blue), e.blue) <= e.tol, e.tag, "dac_blue (R4)", int'(dac_blue), e.blue);
        check(dac_blank_n && dac_sync_n, "R6", "blank/sync", int'({dac_blank_n, dac_sync_n}), 3);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 32'h0, "R7");
    run(5, "R3");                                   // zero word, phase frozen
    step(1'b0, 1'b1, 32'h0100_0000, "R2");          // index +1 per cycle
    run(300, "R3");                                 // sweep every index, R5
    step(1'b0, 1'b1, 32'h4000_0000, "R2");          // quarter turn per cycle
    run(20, "R4");
    step(1'b0, 1'b1, 32'd21904, "R2");              // 255 Hz word
    run(40, "R1");
    step(1'b0, 1'b1, 32'hFF00_0000, "R2");          // backward step through the wrap
    run(40, "R1");
    step(1'b0, 1'b1, 32'h0123_4567, "R2");
    step(1'b0, 1'b1, 32'h0F0F_0F0F, "R2");
    step(1'b0, 1'b1, 32'h8000_0001, "R2");
    run(20, "R1");
    step(1'b1, 1'b0, 32'h0, "R7");                  // reset during a run
    step(1'b1, 1'b1, 32'h0400_0000, "R7");          // write ignored under reset
    run(3, "R7");
    step(1'b0, 1'b1, 32'h0400_0000, "R2");
    run(150, "R1");
    @(negedge clk);
    tune_we = 1'b0;
    repeat (3) @(posedge clk);
    #6;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule